// File: doc/BRIEF.md
# Saturating Clear-on-Read Receive Event Counters

This block keeps three 8-bit statistics counters for a receive path. One counts frames with a bad frame check sequence. One counts frames that ended off a byte boundary. One counts frames that were lost. A frame can be lost because the receiver was only observing traffic, or because local buffer space ran out. Each counter advances on a one-cycle pulse from the event logic. When a counter reaches its maximum value it stops there and does not wrap.

The host reads the counters through a small register read port. A read strobe with an address selects one counter. Its value appears on the read data output on the following cycle, and the same read sets that counter back to zero. A single shared level interrupt warns the host while any counter is close to saturation. The host then drains the counters by reading them.

Top module: `rx_evt_counters`

## Requirements
- R1: A synchronous active-high reset clears all three counters, the read data output and the interrupt to zero.
- R2: A counter holding 255 stays at 255 when further increment pulses arrive, until a host read clears it.
- R3: When rd_en is high at a clock edge, rd_data shows the value the addressed counter held before that edge, from the next cycle onward. rd_data keeps that value until the next read. The address encoding is 0 for the bad-checksum counter, 1 for the misalignment counter and 2 for the lost-frame counter.
- R4: A host read of address 0, 1 or 2 with no increment on that counter in the same cycle leaves that counter at zero.
- R5: An increment pulse on a counter below 255 raises it by exactly one on the next edge. The other counters are not affected.
- R6: irq is high exactly when at least one counter holds 192 or more. It changes in the same cycle that the counter value changes.
- R7: A read with address 3 returns zero on rd_data and changes no counter.
- R8: A read and an increment on the same counter in the same cycle return the value from before the increment, and leave that counter at 1.
- R9: The two lost-frame inputs, observe-only miss and buffer-full miss, drive one merged increment. If both are high in one cycle, the lost-frame counter advances by one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inc_crc | input | 1 | One-cycle pulse: frame with bad checksum |
| inc_align | input | 1 | One-cycle pulse: frame ended off a byte boundary |
| inc_miss_mon | input | 1 | One-cycle pulse: frame dropped in observe-only mode |
| inc_miss_full | input | 1 | One-cycle pulse: frame dropped because the buffer was full |
| rd_en | input | 1 | Host read strobe, one cycle per read |
| rd_addr | input | 2 | Counter select for the read |
| rd_data | output | 8 | Value returned by the last read |
| irq | output | 1 | Level interrupt, high while any counter is at or above 192 |

## Verification
The assertions assume that each increment input is sampled once per edge, so a pulse held for several cycles counts as several events. They also assume that a read is a single-cycle strobe and that rd_addr is valid whenever rd_en is high. The stimulus drives every input on the falling edge and gives each input a defined value in every cycle. Pulses are driven for exactly the number of events intended. Reads to address 3 are issued on purpose, to exercise the unmapped slot.

// File: rtl/evt_cnt_pkg.sv
package evt_cnt_pkg;

    // Fixed slot order of the host read map
    typedef enum logic [1:0] {
        SLOT_CRC   = 2'd0,
        SLOT_ALIGN = 2'd1,
        SLOT_MISS  = 2'd2,
        SLOT_NONE  = 2'd3
    } cnt_slot_e;

    // Per-counter control for one cycle
    typedef struct packed {
        logic clr;
        logic inc;
    } cnt_ctl_t;

    // Next value of a saturating counter. A clear combined with an
    // increment yields 1, so no event is lost.
    function automatic logic [15:0] sat_next(input logic [15:0] cur,
                                             input logic [15:0] top,
                                             input cnt_ctl_t    ctl);
        logic [15:0] nxt;
        nxt = cur;
        if (ctl.clr)
            nxt = ctl.inc ? 16'd1 : 16'd0;
        else if (ctl.inc && (cur != top))
            nxt = cur + 16'd1;
        return nxt;
    endfunction

endpackage

// File: rtl/evt_sat_counter.sv
module evt_sat_counter
    import evt_cnt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  cnt_ctl_t     ctl,
    output logic [W-1:0] cnt
);
    localparam logic [15:0] TOP = 16'((1 << W) - 1);

    logic [15:0] wide_cur;
    logic [15:0] wide_nxt;

    always_comb begin
        wide_cur = 16'(cnt);
        wide_nxt = sat_next(wide_cur, TOP, ctl);
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else
            cnt <= wide_nxt[W-1:0];
    end
endmodule

// File: rtl/evt_read_port.sv
module evt_read_port #(
    parameter int W      = 8,
    parameter int N      = 3,
    parameter int ADDR_W = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N-1:0][W-1:0] cnts,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [N-1:0]        clr,
    output logic [W-1:0]        rd_data
);
    logic         hit;
    logic [W-1:0] sel_val;

    always_comb begin
        hit     = rd_en && (int'(rd_addr) < N);
        sel_val = '0;
        for (int k = 0; k < N; k++)
            if (int'(rd_addr) == k)
                sel_val = cnts[k];
    end

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_clr
            assign clr[g] = hit && (int'(rd_addr) == g);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            rd_data <= '0;
        else if (rd_en)
            rd_data <= hit ? sel_val : '0;
    end
endmodule

// File: rtl/evt_warn_irq.sv
module evt_warn_irq #(
    parameter int W     = 8,
    parameter int N     = 3,
    parameter int LEVEL = 192
) (
    input  logic [N-1:0][W-1:0] cnts,
    output logic                irq
);
    localparam logic [W-1:0] THR = W'(LEVEL);

    logic [N-1:0] above;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_cmp
            assign above[g] = (cnts[g] >= THR);
        end
    endgenerate

    assign irq = |above;
endmodule

// File: rtl/rx_evt_counters.sv
module rx_evt_counters
    import evt_cnt_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int WARN_LEVEL = 192
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc_crc,
    input  logic             inc_align,
    input  logic             inc_miss_mon,
    input  logic             inc_miss_full,
    input  logic             rd_en,
    input  logic [1:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    output logic             irq
);
    localparam int NUM_CNT = 3;
    localparam int ADDR_W  = 2;

    logic [NUM_CNT-1:0]            inc_vec;
    logic [NUM_CNT-1:0]            clr_vec;
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q;

    // Both loss sources merge into one increment for the lost-frame slot
    always_comb begin
        inc_vec            = '0;
        inc_vec[SLOT_CRC]  = inc_crc;
        inc_vec[SLOT_ALIGN]= inc_align;
        inc_vec[SLOT_MISS] = inc_miss_mon | inc_miss_full;
    end

    genvar g;
    generate
        for (g = 0; g < NUM_CNT; g++) begin : g_cnt
            cnt_ctl_t ctl;
            assign ctl.clr = clr_vec[g];
            assign ctl.inc = inc_vec[g];
            evt_sat_counter #(.W(CNT_W)) u_cnt (
                .clk (clk),
                .rst (rst),
                .ctl (ctl),
                .cnt (cnt_q[g])
            );
        end
    endgenerate

    evt_read_port #(.W(CNT_W), .N(NUM_CNT), .ADDR_W(ADDR_W)) u_rd (
        .clk     (clk),
        .rst     (rst),
        .cnts    (cnt_q),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .clr     (clr_vec),
        .rd_data (rd_data)
    );

    evt_warn_irq #(.W(CNT_W), .N(NUM_CNT), .LEVEL(WARN_LEVEL)) u_irq (
        .cnts (cnt_q),
        .irq  (irq)
    );
endmodule

// File: rtl/rx_evt_counters_chk.sv
module rx_evt_counters_chk #(
    parameter int W     = 8,
    parameter int N     = 3,
    parameter int LEVEL = 192
) (
    input logic                clk,
    input logic                rst,
    input logic [N-1:0]        inc,
    input logic                inc_miss_mon,
    input logic                inc_miss_full,
    input logic                rd_en,
    input logic [1:0]          rd_addr,
    input logic [W-1:0]        rd_data,
    input logic                irq,
    input logic [N-1:0][W-1:0] cnts
);
    localparam logic [W-1:0] MAXV = '1;

    logic [W-1:0] sel;
    logic         any_hi;
    always_comb begin
        sel    = '0;
        any_hi = 1'b0;
        for (int k = 0; k < N; k++) begin
            if (int'(rd_addr) == k) sel = cnts[k];
            if (cnts[k] >= W'(LEVEL)) any_hi = 1'b1;
        end
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (rd_data == '0) && !irq);

    // R3
    read_value_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en && (rd_addr != 2'd3) |=> rd_data == $past(sel));

    // R3
    read_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

    // R6
    irq_level_chk: assert property (@(posedge clk) disable iff (rst)
        irq == any_hi);

    // R7
    bad_addr_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en && (rd_addr == 2'd3) |=> rd_data == '0);

    // R9
    miss_merge_chk: assert property (@(posedge clk) disable iff (rst)
        (inc_miss_mon | inc_miss_full) == inc[N-1]);

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_p
            logic hit;
            assign hit = rd_en && (int'(rd_addr) == g);

            // R2
            sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
                !hit && (cnts[g] == MAXV) |=> cnts[g] == MAXV);

            // R4
            read_clear_chk: assert property (@(posedge clk) disable iff (rst)
                hit && !inc[g] |=> cnts[g] == '0);

            // R5
            step_one_chk: assert property (@(posedge clk) disable iff (rst)
                !hit && inc[g] && (cnts[g] != MAXV) |=> cnts[g] == $past(cnts[g]) + W'(1));

            // R7
            idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
                !hit && !inc[g] |=> $stable(cnts[g]));

            // R8
            read_inc_chk: assert property (@(posedge clk) disable iff (rst)
                hit && inc[g] |=> cnts[g] == W'(1));
        end
    endgenerate
endmodule

bind rx_evt_counters rx_evt_counters_chk #(.W(CNT_W), .N(NUM_CNT), .LEVEL(WARN_LEVEL)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .inc           (inc_vec),
    .inc_miss_mon  (inc_miss_mon),
    .inc_miss_full (inc_miss_full),
    .rd_en         (rd_en),
    .rd_addr       (rd_addr),
    .rd_data       (rd_data),
    .irq           (irq),
    .cnts          (cnt_q)
);

// File: tb/sim_rx_evt_counters.sv
module sim_rx_evt_counters;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       inc_crc = 0, inc_align = 0, inc_miss_mon = 0, inc_miss_full = 0;
    logic       rd_en = 0;
    logic [1:0] rd_addr = 0;
    logic [7:0] rd_data;
    logic       irq;

    int n_cmp = 0;
    int n_bad = 0;
    int m_cnt[3];
    int m_rd = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_evt_counters u0 (
        .clk(clk), .rst(rst),
        .inc_crc(inc_crc), .inc_align(inc_align),
        .inc_miss_mon(inc_miss_mon), .inc_miss_full(inc_miss_full),
        .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq(irq)
    );

    task automatic compare(input string tag);
        bit exp_irq;
        exp_irq = 0;
        foreach (m_cnt[k]) if (m_cnt[k] >= 192) exp_irq = 1;
        n_cmp++;
        if (int'(rd_data) != m_rd) begin
            n_bad++;
            $display("FAIL %s/R3 rd_data actual=%0d expected=%0d", tag, rd_data, m_rd);
        end
        n_cmp++;
        if (irq != exp_irq) begin
            n_bad++;
            $display("FAIL %s/R6 irq actual=%0d expected=%0d", tag, irq, exp_irq);
        end
    endtask

    // One clock: drive, let the edge pass, advance the model, compare
    task automatic step(input string tag, input bit c, input bit a,
                        input bit mm, input bit mf, input bit rd, input int ad);
        int  old[3];
        bit  inc[3];
        inc_crc = c; inc_align = a; inc_miss_mon = mm; inc_miss_full = mf;
        rd_en = rd; rd_addr = 2'(ad);
        @(posedge clk);
        old = m_cnt;
        inc[0] = c; inc[1] = a; inc[2] = mm | mf;
        if (rd) m_rd = (ad < 3) ? old[ad] : 0;
        for (int k = 0; k < 3; k++) begin
            if (rd && ad == k) m_cnt[k] = inc[k] ? 1 : 0;
            else if (inc[k] && old[k] < 255) m_cnt[k] = old[k] + 1;
        end
        @(negedge clk);
        compare(tag);
    endtask

    task automatic idle(input string tag);
        step(tag, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic rd(input string tag, input int ad);
        step(tag, 0, 0, 0, 0, 1, ad);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        foreach (m_cnt[k]) m_cnt[k] = 0;
        // R1: reset state
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare("R1");
        rst = 0;

        // R5: distinct counts per counter, independent
        for (int i = 0; i < 5; i++) step("R5", 1, 0, 0, 0, 0, 0);
        for (int i = 0; i < 3; i++) step("R5", 0, 1, 0, 0, 0, 0);
        for (int i = 0; i < 2; i++) step("R5", 1, 1, 1, 0, 0, 0);
        idle("R5");
        // R3 and R4: read each slot, read again to see cleared value
        rd("R3", 0); rd("R4", 0);
        rd("R3", 1); rd("R4", 1);
        rd("R3", 2); rd("R4", 2);
        idle("R3");

        // R9: both loss inputs in one cycle add one; each alone adds one
        step("R9", 0, 0, 1, 1, 0, 0);
        step("R9", 0, 0, 0, 1, 0, 0);
        step("R9", 0, 0, 1, 0, 0, 0);
        rd("R9", 2);

        // R8: read and increment together
        for (int i = 0; i < 4; i++) step("R8", 0, 1, 0, 0, 0, 0);
        step("R8", 0, 1, 0, 0, 1, 1);
        rd("R8", 1);

        // R7: unmapped address returns zero, leaves counters alone
        for (int i = 0; i < 6; i++) step("R7", 1, 0, 0, 0, 0, 0);
        rd("R7", 3);
        step("R7", 0, 1, 0, 0, 1, 3);
        rd("R7", 0);
        rd("R7", 1);

        // R6: threshold crossing on the lost-frame counter
        for (int i = 0; i < 191; i++) step("R6", 0, 0, i % 2 == 0, i % 2 == 1, 0, 0);
        idle("R6");
        step("R6", 0, 0, 1, 0, 0, 0);
        idle("R6");
        rd("R6", 2);
        idle("R6");

        // R2: saturate the alignment counter and keep pulsing
        for (int i = 0; i < 270; i++) step("R2", 0, 1, 0, 0, 0, 0);
        for (int i = 0; i < 10; i++) step("R2", 1, 1, 0, 0, 0, 0);
        rd("R2", 1);
        rd("R2", 0);
        rd("R2", 1);

        // R1: reset in mid-count clears everything
        for (int i = 0; i < 200; i++) step("R1", 1, 1, 1, 0, 0, 0);
        rst = 1;
        @(posedge clk);
        foreach (m_cnt[k]) m_cnt[k] = 0;
        m_rd = 0;
        @(negedge clk);
        compare("R1");
        rst = 0;
        rd("R1", 0); rd("R1", 1); rd("R1", 2);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule